// File: doc/BRIEF.md
# USB Endpoint Halt Controller

This block decides, for every IN or OUT token a USB device receives, whether the endpoint answers with its normal handshake or with STALL. Firmware asks for a halt by setting a per-endpoint request bit through a small register write port. When a token arrives for an endpoint that is not already halted, the block looks at that request bit. If the bit is set, the block latches a sticky halt status for the endpoint and selects STALL.

Once the status is latched, the request bit is no longer consulted. Every token to that endpoint is stalled until the host sends a Clear Feature (endpoint halt) for it. Clear Feature clears only the sticky status. If firmware has not dropped its request by then, the next token halts the endpoint again.

An optional mode makes the hardware drop the request bit at the moment the status latches. This lets firmware issue a one-shot halt. The packet engine takes the handshake choice one cycle after it presents the token.

Top module: `usb_ep_halt_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high), all request bits read 0, `hs_vld` is 0, no endpoint is halted and the auto-drop mode is off.
- R2: A write with `cfg_wr_en`=1 and `cfg_addr`=0 loads `cfg_wdata` (bit i is endpoint i) into the request bits, and `req_rd` shows the new value on the next cycle.
- R3: A token to an endpoint whose halt status is clear and whose request bit is 1 gets `hs_stall`=1 (STALL) and latches the halt status.
- R4: A token to an endpoint whose halt status is clear and whose request bit is 0 gets `hs_stall`=0 (normal handshake).
- R5: The auto-drop mode is written with `cfg_addr`=1, using bit 0 of `cfg_wdata`. With the mode at 1, latching the halt status clears that endpoint's request bit in the same cycle. With the mode at 0, the request bit stays 1.
- R6: While an endpoint's halt status is 1, each token to it gets STALL, whatever its request bit holds.
- R7: A Clear Feature strobe for an endpoint clears its halt status and leaves every request bit unchanged. With the request bit at 0, the next token to that endpoint gets a normal handshake.
- R8: If Clear Feature arrives while the request bit is still 1, the next token to that endpoint gets STALL again.
- R9: The request, status and decision of each endpoint are independent of the other endpoints.
- R10: If a token and a Clear Feature name the same endpoint in the same cycle, Clear Feature wins. The token is then decided on the request bit alone, as if the status were clear.
- R11: If a firmware write to the request bits and a hardware auto-drop hit the same bit in the same cycle, the written value is kept.
- R12: A USB bus reset (`bus_rst` high) clears request bits, halt status, the mode and `hs_vld`, just as `rst` does.
- R13: `hs_vld` is 1 exactly one cycle after each `tok_vld` pulse and 0 in cycles that follow no token. `hs_stall` is 1 for STALL and 0 for a normal handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | USB bus reset, synchronous, active high |
| cfg_wr_en | input | 1 | Firmware register write strobe |
| cfg_addr | input | 1 | 0 = request bits, 1 = auto-drop mode (bit 0) |
| cfg_wdata | input | NUM_EP | Write data |
| tok_vld | input | 1 | IN/OUT token received strobe |
| tok_ep | input | EPW | Endpoint of the token |
| clrf_vld | input | 1 | Clear Feature (endpoint halt) strobe |
| clrf_ep | input | EPW | Endpoint of the Clear Feature |
| hs_vld | output | 1 | Handshake choice valid, one cycle after the token |
| hs_stall | output | 1 | 1 = STALL, 0 = normal handshake |
| req_rd | output | NUM_EP | Readback of the request bits |

## Verification
The hardest cases to reach from the ports are two same-cycle collisions. In one, a token meets a Clear Feature for the same endpoint while the status is set. In the other, a token triggers an auto-drop while firmware writes the request register.

Each collision needs preparation first. The endpoint is halted by an earlier token, and the mode and request bits are set by prior writes. The bench then raises both strobes in a single cycle. The outcome is read only through `hs_stall`, through `req_rd`, and through the decision on a following token, which shows whether the status survived.

// File: rtl/usb_halt_pkg.sv
`timescale 1ns/1ps
package usb_halt_pkg;

    // Register select on the firmware write port
    typedef enum logic {
        CFG_REQ  = 1'b0,
        CFG_MODE = 1'b1
    } cfg_sel_e;

    // Handshake choice returned to the packet engine
    typedef enum logic {
        HS_NORMAL = 1'b0,
        HS_STALL  = 1'b1
    } hs_sel_e;

    // State held for one endpoint
    typedef struct packed {
        logic req;   // firmware halt request
        logic sts;   // sticky halt status
    } ep_state_t;

    // Event strobes decoded for one endpoint
    typedef struct packed {
        logic tok;
        logic clr;
    } ep_evt_t;

    function automatic logic ep_match(input logic vld, input int unsigned ep,
                                      input int unsigned idx);
        return vld && (ep == idx);
    endfunction

endpackage

// File: rtl/halt_evt_decode.sv
`timescale 1ns/1ps
module halt_evt_decode
    import usb_halt_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW = $clog2(NUM_EP)
) (
    input  logic                 tok_vld,
    input  logic [EPW-1:0]       tok_ep,
    input  logic                 clrf_vld,
    input  logic [EPW-1:0]       clrf_ep,
    output ep_evt_t [NUM_EP-1:0] evt
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
        always_comb begin
            evt[i].tok = ep_match(tok_vld, int'(tok_ep), i);
            evt[i].clr = ep_match(clrf_vld, int'(clrf_ep), i);
        end
    end
endmodule

// File: rtl/halt_ep_slice.sv
`timescale 1ns/1ps
module halt_ep_slice
    import usb_halt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_rst,
    input  logic      wr_req,
    input  logic      wr_bit,
    input  logic      auto_drop,
    input  ep_evt_t   evt,
    output ep_state_t state,
    output logic      stall_dec
);
    ep_state_t st_q, st_d;
    logic      eff_sts;
    logic      latch;

    always_comb begin
        // Clear Feature in the same cycle overrides the held status
        eff_sts   = st_q.sts & ~evt.clr;
        stall_dec = eff_sts | st_q.req;
        latch     = evt.tok & ~eff_sts & st_q.req;

        st_d = st_q;
        if (latch)
            st_d.sts = 1'b1;
        else if (evt.clr)
            st_d.sts = 1'b0;

        if (wr_req)
            st_d.req = wr_bit;
        else if (latch && auto_drop)
            st_d.req = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/halt_resp_stage.sv
`timescale 1ns/1ps
module halt_resp_stage
    import usb_halt_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              tok_vld,
    input  logic [EPW-1:0]    tok_ep,
    input  logic [NUM_EP-1:0] stall_dec,
    output logic              hs_vld,
    output logic              hs_stall
);
    hs_sel_e hs_q;
    logic    vld_q;
    hs_sel_e hs_d;

    always_comb begin
        hs_d = stall_dec[tok_ep] ? HS_STALL : HS_NORMAL;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            vld_q <= 1'b0;
            hs_q  <= HS_NORMAL;
        end else begin
            vld_q <= tok_vld;
            hs_q  <= tok_vld ? hs_d : HS_NORMAL;
        end
    end

    assign hs_vld   = vld_q;
    assign hs_stall = (hs_q == HS_STALL);
endmodule

// File: rtl/usb_ep_halt_ctrl.sv
`timescale 1ns/1ps
module usb_ep_halt_ctrl
    import usb_halt_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_addr,
    input  logic [NUM_EP-1:0] cfg_wdata,
    input  logic              tok_vld,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              clrf_vld,
    input  logic [EPW-1:0]    clrf_ep,
    output logic              hs_vld,
    output logic              hs_stall,
    output logic [NUM_EP-1:0] req_rd
);
    ep_evt_t   [NUM_EP-1:0] evt;
    ep_state_t [NUM_EP-1:0] ep_st;
    logic      [NUM_EP-1:0] stall_dec;
    logic      [NUM_EP-1:0] sts_q;
    logic                   auto_drop_q;
    logic                   wr_req;

    assign wr_req = cfg_wr_en && (cfg_sel_e'(cfg_addr) == CFG_REQ);

    always_ff @(posedge clk) begin
        if (rst || bus_rst)
            auto_drop_q <= 1'b0;
        else if (cfg_wr_en && (cfg_sel_e'(cfg_addr) == CFG_MODE))
            auto_drop_q <= cfg_wdata[0];
    end

    halt_evt_decode #(.NUM_EP(NUM_EP)) u_dec (
        .tok_vld  (tok_vld),
        .tok_ep   (tok_ep),
        .clrf_vld (clrf_vld),
        .clrf_ep  (clrf_ep),
        .evt      (evt)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        halt_ep_slice u_slice (
            .clk       (clk),
            .rst       (rst),
            .bus_rst   (bus_rst),
            .wr_req    (wr_req),
            .wr_bit    (cfg_wdata[i]),
            .auto_drop (auto_drop_q),
            .evt       (evt[i]),
            .state     (ep_st[i]),
            .stall_dec (stall_dec[i])
        );
        assign req_rd[i] = ep_st[i].req;
        assign sts_q[i]  = ep_st[i].sts;
    end

    halt_resp_stage #(.NUM_EP(NUM_EP)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .bus_rst   (bus_rst),
        .tok_vld   (tok_vld),
        .tok_ep    (tok_ep),
        .stall_dec (stall_dec),
        .hs_vld    (hs_vld),
        .hs_stall  (hs_stall)
    );
endmodule

// File: rtl/usb_ep_halt_chk.sv
`timescale 1ns/1ps
module usb_ep_halt_chk #(
    parameter int NUM_EP = 4,
    localparam int EPW = $clog2(NUM_EP)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rst,
    input logic              cfg_wr_en,
    input logic              cfg_addr,
    input logic [NUM_EP-1:0] cfg_wdata,
    input logic              tok_vld,
    input logic [EPW-1:0]    tok_ep,
    input logic              clrf_vld,
    input logic [EPW-1:0]    clrf_ep,
    input logic              hs_vld,
    input logic              hs_stall,
    input logic [NUM_EP-1:0] req_rd,
    input logic [NUM_EP-1:0] sts_vec
);
    AST_HS_AFTER_TOKEN: assert property (@(posedge clk) disable iff (rst || bus_rst)
        tok_vld |=> hs_vld); // R13
    AST_HS_IDLE: assert property (@(posedge clk) disable iff (rst || bus_rst)
        !tok_vld |=> !hs_vld); // R13
    AST_REQ_WRITE: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (cfg_wr_en && !cfg_addr) |=> (req_rd == $past(cfg_wdata))); // R2
    AST_HALTED_STALLS: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (tok_vld && sts_vec[tok_ep] && !(clrf_vld && clrf_ep == tok_ep)) |=> hs_stall); // R6
    AST_IDLE_NORMAL: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (tok_vld && !sts_vec[tok_ep] && !req_rd[tok_ep]) |=> !hs_stall); // R4
    AST_CLRF_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (clrf_vld && !cfg_wr_en && !tok_vld) |=> (req_rd == $past(req_rd))); // R7
    AST_CLRF_CLEARS: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (clrf_vld && !(tok_vld && tok_ep == clrf_ep)) |=> !sts_vec[$past(clrf_ep)]); // R7
    AST_BUS_RESET: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (req_rd == '0 && sts_vec == '0 && !hs_vld)); // R12
endmodule

bind usb_ep_halt_ctrl usb_ep_halt_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rst   (bus_rst),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tok_vld   (tok_vld),
    .tok_ep    (tok_ep),
    .clrf_vld  (clrf_vld),
    .clrf_ep   (clrf_ep),
    .hs_vld    (hs_vld),
    .hs_stall  (hs_stall),
    .req_rd    (req_rd),
    .sts_vec   (sts_q)
);

// File: tb/sim_usb_ep_halt_ctrl.sv
`timescale 1ns/1ps
module sim_usb_ep_halt_ctrl;
    localparam int NUM_EP = 4;
    localparam int EPW = 2;

    logic clk = 1'b0;
    logic rst, bus_rst, cfg_wr_en, cfg_addr, tok_vld, clrf_vld;
    logic [NUM_EP-1:0] cfg_wdata;
    logic [EPW-1:0] tok_ep, clrf_ep;
    logic hs_vld, hs_stall;
    logic [NUM_EP-1:0] req_rd;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk; // 125 MHz

    usb_ep_halt_ctrl #(.NUM_EP(NUM_EP)) u0 (
        .clk(clk), .rst(rst), .bus_rst(bus_rst),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tok_vld(tok_vld), .tok_ep(tok_ep),
        .clrf_vld(clrf_vld), .clrf_ep(clrf_ep),
        .hs_vld(hs_vld), .hs_stall(hs_stall), .req_rd(req_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr_en = 0; cfg_addr = 0; cfg_wdata = '0;
        tok_vld = 0; tok_ep = '0; clrf_vld = 0; clrf_ep = '0; bus_rst = 0;
    endtask

    task automatic fw_write(input logic addr, input logic [NUM_EP-1:0] data);
        @(negedge clk);
        cfg_wr_en = 1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        idle();
    endtask

    task automatic clear_feat(input int ep);
        @(negedge clk);
        clrf_vld = 1; clrf_ep = ep[EPW-1:0];
        @(negedge clk);
        idle();
    endtask

    // token then check the decision one cycle later
    task automatic token(input int ep, input logic exp_stall, input string tag);
        @(negedge clk);
        tok_vld = 1; tok_ep = ep[EPW-1:0];
        @(negedge clk);
        idle();
        chk({tag, " hs_vld"}, 32'(hs_vld), 32'd1);
        chk({tag, " hs_stall"}, 32'(hs_stall), 32'(exp_stall));
    endtask

    task automatic t_reset();
        chk("R1 req after reset", 32'(req_rd), 32'd0);
        chk("R1 hs_vld after reset", 32'(hs_vld), 32'd0);
        token(2, 1'b0, "R1 R4 token after reset");
        @(negedge clk);
        chk("R13 hs_vld low after idle cycle", 32'(hs_vld), 32'd0);
    endtask

    task automatic t_readback();
        fw_write(1'b0, 4'b1010);
        chk("R2 readback 1010", 32'(req_rd), 32'hA);
        fw_write(1'b0, 4'b0101);
        chk("R2 readback 0101", 32'(req_rd), 32'h5);
        fw_write(1'b0, 4'b0000);
        chk("R2 readback zero", 32'(req_rd), 32'h0);
    endtask

    task automatic t_basic_halt();
        fw_write(1'b0, 4'b0010);
        token(1, 1'b1, "R3 request halts ep1");
        chk("R5 mode0 keeps request", 32'(req_rd), 32'h2);
        token(0, 1'b0, "R9 ep0 unaffected");
        clear_feat(1);
        chk("R7 clear feature keeps request", 32'(req_rd), 32'h2);
        token(1, 1'b1, "R8 re-halt after clear with request set");
        fw_write(1'b0, 4'b0000);
        token(1, 1'b1, "R6 status holds with request 0");
        clear_feat(1);
        token(1, 1'b0, "R7 normal after clear and request 0");
    endtask

    task automatic t_autodrop();
        fw_write(1'b1, 4'b0001);
        fw_write(1'b0, 4'b0100);
        token(2, 1'b1, "R3 ep2 halts in auto mode");
        chk("R5 auto mode drops request", 32'(req_rd), 32'h0);
        token(2, 1'b1, "R6 ep2 still halted");
        clear_feat(2);
        token(2, 1'b0, "R7 ep2 normal after clear");
        fw_write(1'b1, 4'b0000);
    endtask

    task automatic t_collision();
        fw_write(1'b0, 4'b1000);
        token(3, 1'b1, "R3 ep3 halts");
        // same-cycle token and clear, request still 1
        @(negedge clk);
        tok_vld = 1; tok_ep = 2'd3; clrf_vld = 1; clrf_ep = 2'd3;
        @(negedge clk);
        idle();
        chk("R10 collision with request 1 stalls", 32'(hs_stall), 32'd1);
        fw_write(1'b0, 4'b0000);
        token(3, 1'b1, "R10 status relatched by collision token");
        @(negedge clk);
        tok_vld = 1; tok_ep = 2'd3; clrf_vld = 1; clrf_ep = 2'd3;
        @(negedge clk);
        idle();
        chk("R10 collision with request 0 normal", 32'(hs_stall), 32'd0);
        token(3, 1'b0, "R10 status cleared by collision");
    endtask

    task automatic t_write_wins();
        fw_write(1'b1, 4'b0001);
        fw_write(1'b0, 4'b0001);
        @(negedge clk);
        tok_vld = 1; tok_ep = 2'd0;
        cfg_wr_en = 1; cfg_addr = 1'b0; cfg_wdata = 4'b0011;
        @(negedge clk);
        idle();
        chk("R11 token stalls", 32'(hs_stall), 32'd1);
        chk("R11 write beats auto drop", 32'(req_rd), 32'h3);
        fw_write(1'b0, 4'b0000);
        fw_write(1'b1, 4'b0000);
        clear_feat(0);
        token(0, 1'b0, "R9 ep0 normal after cleanup");
    endtask

    task automatic t_bus_reset();
        fw_write(1'b1, 4'b0001);
        fw_write(1'b0, 4'b1111);
        token(1, 1'b1, "R12 setup halt ep1");
        @(negedge clk);
        bus_rst = 1;
        @(negedge clk);
        idle();
        chk("R12 request cleared", 32'(req_rd), 32'h0);
        chk("R12 hs_vld cleared", 32'(hs_vld), 32'd0);
        token(1, 1'b0, "R12 ep1 status cleared");
        fw_write(1'b0, 4'b0001);
        token(0, 1'b1, "R12 ep0 halts");
        chk("R12 mode cleared, request kept", 32'(req_rd), 32'h1);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_readback();
        t_basic_halt();
        t_autodrop();
        t_collision();
        t_write_wins();
        t_bus_reset();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule